// File: doc/BRIEF.md
# Link squelch recovery sequencer

This block runs a small recovery routine that helps an Ethernet PHY find link in rare cases where link stays down under auto-negotiation. Once per management tick, and only after the link indication for that tick has settled, it looks at the link state. While link is down it steps through three PHY register settings: extended squelch first, then an equalizer training value, then the equalizer default. After every step it re-launches auto-negotiation, then waits a fixed number of ticks before the next attempt. When link appears it puts back the default for whichever setting it changed last, and it starts again from the first step.

Register writes leave the block through a request/acknowledge port towards a management frame engine. One tick can need up to three writes; they are issued one after another, and the block reports busy until all of them are acknowledged. Ticks that arrive while busy are dropped. An enable input, held low when speed is forced or when the attached PHY does not need the routine, makes every tick a no-op.

Top module: `link_recover_seq`

## Requirements
- R1: After reset no write is requested, busy is low, the step index is 0 and the hold-off count is 0. So the first accepted tick with link down acts at once.
- R2: A tick with enable low changes no state and requests no write.
- R3: A tick with link down and a non-zero hold-off count issues no write and lowers the count by one.
- R4: A tick with link down, zero hold-off and step 0 writes the extended-squelch value (parameter, default 0x0008) to the special control register (default address 0x10) and moves to step 1.
- R5: A tick with link down, zero hold-off and step 1 writes 0x0000 to special control, then 0x2010 to the equalizer register (default address 0x1A), and moves to step 2.
- R6: A tick with link down, zero hold-off and step 2 writes 0x3000 to the equalizer register and returns to step 0. The step index never takes the value 3.
- R7: Each step action ends with a write of 0x1200 to the basic control register (default address 0x00): auto-negotiation enable is bit 12 and restart is bit 9. The hold-off count is then loaded with 3, so exactly three ticks with link down pass quietly before the next action.
- R8: A tick with link up writes 0x0000 to special control when at step 1, writes 0x3000 to the equalizer when at step 2, and writes nothing at step 0. In every case both the step index and the hold-off count become 0.
- R9: A write request stays high with address and data unchanged until the cycle in which it is acknowledged. The writes of one tick go out in the order listed above, and the next one is presented in the cycle after the acknowledge.
- R10: Busy is high while any write of the current tick is outstanding. A tick that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per management tick, given after link status is updated |
| enable | input | 1 | Routine allowed (low when speed is forced or the PHY does not need it) |
| link_up | input | 1 | Current link indication |
| wr_req | output | 1 | Management write request |
| wr_addr | output | 5 | PHY register address of the requested write |
| wr_data | output | 16 | Data of the requested write |
| wr_ack | input | 1 | Write accepted by the management engine |
| busy | output | 1 | Writes of the current tick still outstanding |

## Verification
The step index and hold-off count are internal. A wrong value shows up only at the next accepted tick: as a write to the wrong register, a wrong data word, or an action one tick too early or too late. The reference model therefore follows every tick and compares request, address, data and busy on every cycle. A corrupted step or count is caught at the first tick that acts on it, which is at most four ticks later. Link-up ticks are placed after every possible count of prior link-down ticks, so the restore path is reached from each step and from each hold-off value.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int AW = 5;
  localparam int DW = 16;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_op_t;

  // basic control word: auto-negotiation enable (bit 12) and restart (bit 9)
  function automatic logic [DW-1:0] an_restart_word();
    logic [DW-1:0] w;
    w = '0;
    w[12] = 1'b1;
    w[9]  = 1'b1;
    return w;
  endfunction

  // cyclic step order 0 -> 1 -> 2 -> 0
  function automatic logic [1:0] step_after(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction
endpackage

// File: rtl/lsq_plan.sv
module lsq_plan
  import lsq_pkg::*;
#(
  parameter logic [AW-1:0] SPEC_ADDR   = 5'h10,
  parameter logic [AW-1:0] EQ_ADDR     = 5'h1A,
  parameter logic [AW-1:0] CTRL_ADDR   = 5'h00,
  parameter logic [DW-1:0] SQ_VAL      = 16'h0008,
  parameter logic [DW-1:0] EQ_TRAIN    = 16'h2010,
  parameter logic [DW-1:0] EQ_DEFAULT  = 16'h3000,
  parameter int            HOLD_TICKS  = 3,
  parameter int            HW          = 2,
  parameter int            NOPS        = 3,
  parameter int            CW          = 2
) (
  input  logic [1:0]          step_i,
  input  logic [HW-1:0]       hold_i,
  input  logic                link_up_i,
  output wr_op_t [NOPS-1:0]   ops_o,
  output logic [CW-1:0]       cnt_o,
  output logic [1:0]          step_o,
  output logic [HW-1:0]       hold_o
);
  localparam logic [DW-1:0] ZERO = '0;

  always_comb begin
    ops_o  = '0;
    cnt_o  = '0;
    step_o = step_i;
    hold_o = hold_i;
    if (link_up_i) begin
      // undo whichever setting is in force
      case (step_i)
        2'd1: begin ops_o[0] = '{SPEC_ADDR, ZERO};     cnt_o = CW'(1); end
        2'd2: begin ops_o[0] = '{EQ_ADDR, EQ_DEFAULT}; cnt_o = CW'(1); end
        default: ;
      endcase
      step_o = 2'd0;
      hold_o = '0;
    end else if (hold_i != '0) begin
      hold_o = hold_i - 1'b1;
    end else begin
      case (step_i)
        2'd0: begin
          ops_o[0] = '{SPEC_ADDR, SQ_VAL};
          ops_o[1] = '{CTRL_ADDR, an_restart_word()};
          cnt_o    = CW'(2);
        end
        2'd1: begin
          ops_o[0] = '{SPEC_ADDR, ZERO};
          ops_o[1] = '{EQ_ADDR, EQ_TRAIN};
          ops_o[2] = '{CTRL_ADDR, an_restart_word()};
          cnt_o    = CW'(3);
        end
        default: begin
          ops_o[0] = '{EQ_ADDR, EQ_DEFAULT};
          ops_o[1] = '{CTRL_ADDR, an_restart_word()};
          cnt_o    = CW'(2);
        end
      endcase
      step_o = step_after(step_i);
      hold_o = HW'(HOLD_TICKS);
    end
  end
endmodule

// File: rtl/lsq_issue.sv
module lsq_issue
  import lsq_pkg::*;
#(
  parameter int NOPS = 3,
  parameter int CW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  wr_op_t [NOPS-1:0] ops_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              ack_i,
  output logic              req_o,
  output wr_op_t            op_o,
  output logic              busy_o
);
  wr_op_t [NOPS-1:0] q_r;
  logic [CW-1:0]     rem_r;

  assign req_o  = (rem_r != '0);
  assign busy_o = req_o;
  assign op_o   = q_r[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
    end else if (load_i) begin
      q_r   <= ops_i;
      rem_r <= cnt_i;
    end else if (req_o && ack_i) begin
      q_r   <= {wr_op_t'('0), q_r[NOPS-1:1]};
      rem_r <= rem_r - 1'b1;
    end
  end
endmodule

// File: rtl/link_recover_seq.sv
module link_recover_seq
  import lsq_pkg::*;
#(
  parameter logic [AW-1:0] SPEC_ADDR  = 5'h10,
  parameter logic [AW-1:0] EQ_ADDR    = 5'h1A,
  parameter logic [AW-1:0] CTRL_ADDR  = 5'h00,
  parameter logic [DW-1:0] SQ_VAL     = 16'h0008,
  parameter logic [DW-1:0] EQ_TRAIN   = 16'h2010,
  parameter logic [DW-1:0] EQ_DEFAULT = 16'h3000,
  parameter int            HOLD_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          link_up,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          busy
);
  localparam int HW   = $clog2(HOLD_TICKS + 1);
  localparam int NOPS = 3;
  localparam int CW   = $clog2(NOPS + 1);

  logic [1:0]        step_q, step_d;
  logic [HW-1:0]     hold_q, hold_d;
  wr_op_t [NOPS-1:0] plan_ops;
  logic [CW-1:0]     plan_cnt;
  wr_op_t            cur_op;
  logic              tick_take;

  assign tick_take = tick && enable && !busy;

  lsq_plan #(
    .SPEC_ADDR(SPEC_ADDR), .EQ_ADDR(EQ_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .SQ_VAL(SQ_VAL), .EQ_TRAIN(EQ_TRAIN), .EQ_DEFAULT(EQ_DEFAULT),
    .HOLD_TICKS(HOLD_TICKS), .HW(HW), .NOPS(NOPS), .CW(CW)
  ) u_plan (
    .step_i(step_q), .hold_i(hold_q), .link_up_i(link_up),
    .ops_o(plan_ops), .cnt_o(plan_cnt), .step_o(step_d), .hold_o(hold_d)
  );

  lsq_issue #(.NOPS(NOPS), .CW(CW)) u_issue (
    .clk(clk), .rst_n(rst_n), .load_i(tick_take), .ops_i(plan_ops),
    .cnt_i(plan_cnt), .ack_i(wr_ack), .req_o(wr_req), .op_o(cur_op),
    .busy_o(busy)
  );

  assign wr_addr = cur_op.addr;
  assign wr_data = cur_op.data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 2'd0;
      hold_q <= '0;
    end else if (tick_take) begin
      step_q <= step_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
  parameter int HW         = 2,
  parameter int HOLD_TICKS = 3,
  parameter int AW         = 5,
  parameter int DW         = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          enable,
  input logic          link_up,
  input logic          tick_take,
  input logic [1:0]    step_q,
  input logic [HW-1:0] hold_q,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy
);
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !enable |=> $stable(step_q) && $stable(hold_q));

  p_hold_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_take && !link_up && hold_q != '0 |=>
      hold_q == $past(hold_q) - 1'b1 && !wr_req);

  p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_take && !link_up && hold_q == '0 |=>
      wr_req && hold_q == HW'(HOLD_TICKS));

  p_step_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != 2'd3);

  p_linkup_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_take && link_up |=> step_q == 2'd0 && hold_q == '0);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick |=> $stable(step_q) && $stable(hold_q));
endmodule

bind link_recover_seq lsq_checker #(
  .HW(HW), .HOLD_TICKS(HOLD_TICKS), .AW(lsq_pkg::AW), .DW(lsq_pkg::DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .link_up(link_up),
  .tick_take(tick_take), .step_q(step_q), .hold_q(hold_q), .wr_req(wr_req),
  .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
);

// File: tb/sim_link_recover_seq.sv
module sim_link_recover_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SPEC = 'h10, EQ = 'h1A, CTRL = 'h00, SQ = 'h0008;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, enable = 1'b0, link_up = 1'b0;
  logic wr_ack = 1'b0;
  logic wr_req, busy;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0, n_bad = 0, lat = 0, wcnt = 0, cyc = 0;
  int m_step = 0, m_hold = 0;
  int qa[$], qd[$];
  string qt[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_recover_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .link_up(link_up),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic void push(input int a, input int d, input string t);
    qa.push_back(a); qd.push_back(d); qt.push_back(t);
  endfunction

  // reference behaviour, one accepted tick
  function automatic void model_tick();
    if (link_up) begin
      if (m_step == 1) push(SPEC, 0, "R8");
      else if (m_step == 2) push(EQ, 'h3000, "R8");
      m_step = 0; m_hold = 0;
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      case (m_step)
        0: push(SPEC, SQ, "R4");
        1: begin push(SPEC, 0, "R5"); push(EQ, 'h2010, "R5"); end
        default: push(EQ, 'h3000, "R6");
      endcase
      push(CTRL, 'h1200, "R7");
      m_step = (m_step + 1) % 3;
      m_hold = 3;
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_step = 0; m_hold = 0;
      qa.delete(); qd.delete(); qt.delete();
    end else if (qa.size() > 0) begin
      if (wr_ack) begin
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
      end
    end else if (tick && enable) begin
      model_tick();
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 busy", int'(busy), int'(qa.size() > 0));
      if (qa.size() > 0) begin
        check({qt[0], " R9 req"}, int'(wr_req), 1);
        check({qt[0], " R9 addr"}, int'(wr_addr), qa[0]);
        check({qt[0], " R9 data"}, int'(wr_data), qd[0]);
      end else begin
        check("R2 R3 R8 no write", int'(wr_req), 0);
      end
    end
  end

  // acknowledge responder with programmable latency
  always @(negedge clk) begin
    if (wr_ack) begin
      wr_ack = 1'b0; wcnt = 0;
    end else if (wr_req) begin
      if (wcnt >= lat) wr_ack = 1'b1;
      else wcnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pulse(input int gap);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 req in reset", int'(wr_req), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", int'(wr_req), 0);

    // R2: disabled ticks do nothing
    repeat (3) pulse(4);
    enable = 1'b1;

    // R3..R7: full cycles with each ack latency
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int t = 0; t < 13; t++) pulse(20);
    end

    // R8: link-up after every count of prior link-down ticks
    lat = 1;
    for (int k = 0; k < 10; k++) begin
      link_up = 1'b0;
      for (int t = 0; t < k; t++) pulse(20);
      link_up = 1'b1;
      pulse(20);
    end
    link_up = 1'b0;

    // R2 mid-stream: disabled after an action keeps state
    pulse(20);
    enable = 1'b0;
    repeat (4) pulse(4);
    enable = 1'b1;
    repeat (5) pulse(20);

    // R10: tick every cycle with slow acks
    lat = 3;
    @(negedge clk); tick = 1'b1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (c % 37 == 36) link_up = ~link_up;
    end
    tick = 1'b0;
    link_up = 1'b0;
    repeat (40) @(negedge clk);
    check("R10 idle at end", int'(busy), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule